// File: doc/BRIEF.md
# Serial Command Register Writer

This block is a write-only serial slave. A host frames each transaction with an active-low select line, clocks bits in on a serial clock and presents them on a serial data line. The block brings all three lines into the system clock domain and puts the bits together into bytes. The first byte of a frame is an opcode that selects what happens next.

Opcode 0x01 opens a burst. The byte after it names a start address inside the sixteen data registers, and each byte after that is written to the next address in turn. Opcode 0x03 writes a single byte to the control register at address 0x10. Every write leaves the block as a one-cycle strobe with its address and data, to be used by a register file elsewhere in the chip. Any other opcode is refused, and the frame is then dropped until the select line rises.

Top module: `spi_regwr`

## Requirements
- R1: While reset is asserted and after it is released, `wr_en` is 0 and `wr_addr` and `wr_data` hold 0 until the first write.
- R2: Bits are sampled on rising edges of `sck` while `cs_n` is low. They are grouped most significant bit first into bytes, and a byte is complete after every eighth sampled bit counted from the fall of `cs_n`.
- R3: Opcode 0x01 followed by a start address from 0x00 to 0x0F causes each later byte of the frame to be written to the start address, then the start address plus one, and so on.
- R4: Opcode 0x03 causes the next byte to be written to address 0x10. Any further bytes in that frame cause no write.
- R5: In a burst, once address 0x0F has been written, the remaining bytes of the frame cause no write. A burst never writes address 0x10.
- R6: An opcode other than 0x01 or 0x03 causes no write for the rest of the frame.
- R7: If `cs_n` rises part way through a byte, the partial byte is discarded and causes no write. The next frame starts counting bits from zero.
- R8: Each write is a strobe on `wr_en` that lasts exactly one cycle, and its `wr_addr` is never above 0x10.
- R9: A burst whose start address is above 0x0F causes no write.
- R10: Each new frame is decoded from its first byte as an opcode, whatever state the previous frame ended in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Frame select, active low, asynchronous |
| sck | input | 1 | Serial bit clock, asynchronous |
| mosi | input | 1 | Serial data in, asynchronous |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | 5 | Write address, 0x00 to 0x10 |
| wr_data | output | 8 | Write data |

## Verification
A wrong bit count or a lost byte boundary shows up on the first strobe of the frame: the data is shifted or the strobe comes one byte late, within about eight serial clocks. A wrong burst pointer or phase shows up as a write to the wrong address, as a missing strobe, or as an extra one near 0x0F and 0x10. The bench tracks every strobe in a shadow copy of all seventeen registers and counts them, then compares both with a reference model a few cycles after each frame ends, so a fault is reported against the frame that caused it. Random frames are mixed with directed frames that cut a byte short, use an unknown opcode, or run a burst past the last data register.

// File: rtl/spi_regwr_pkg.sv
package spi_regwr_pkg;
    localparam int BYTE_W       = 8;
    localparam int DATA_REG_CNT = 16;
    localparam int ADDR_W       = $clog2(DATA_REG_CNT + 1);
    localparam int CTRL_ADDR    = DATA_REG_CNT;
    localparam int BIT_CNT_W    = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] OPC_BURST = 8'h01;
    localparam logic [BYTE_W-1:0] OPC_CTRL  = 8'h03;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_START,
        PH_BURST,
        PH_CTRL,
        PH_DRAIN
    } phase_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic start_in_range(input logic [BYTE_W-1:0] b);
        return b < BYTE_W'(DATA_REG_CNT);
    endfunction

    function automatic logic is_last_data(input logic [ADDR_W-1:0] a);
        return a == ADDR_W'(DATA_REG_CNT - 1);
    endfunction
endpackage

// File: rtl/spi_regwr_sync.sv
module spi_regwr_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_regwr_deser.sv
module spi_regwr_deser
    import spi_regwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_val
);
    logic                 sck_q;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-2:0]    shreg;
    logic                 sck_rise;

    assign sck_rise = sck_s & ~sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
            byte_val <= '0;
        end else begin
            sck_q    <= sck_s;
            byte_vld <= 1'b0;
            if (cs_n_s) begin
                bit_cnt <= '0;
                shreg   <= '0;
            end else if (sck_rise) begin
                shreg   <= {shreg[BYTE_W-3:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_CNT_W'(BYTE_W - 1)) begin
                    byte_vld <= 1'b1;
                    byte_val <= {shreg, mosi_s};
                end
            end
        end
    end

    // R2
    byte_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

    // R7
    no_byte_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !byte_vld);
endmodule

// File: rtl/spi_regwr_decode.sv
module spi_regwr_decode
    import spi_regwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_val,
    output wr_req_t           req
);
    phase_e            phase;
    logic [ADDR_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_OPCODE;
            ptr   <= '0;
            req   <= '0;
        end else begin
            req.en <= 1'b0;
            if (cs_n_s) begin
                phase <= PH_OPCODE;
            end else if (byte_vld) begin
                unique case (phase)
                    PH_OPCODE: begin
                        if (byte_val == OPC_BURST)     phase <= PH_START;
                        else if (byte_val == OPC_CTRL) phase <= PH_CTRL;
                        else                           phase <= PH_DRAIN;
                    end
                    PH_START: begin
                        if (start_in_range(byte_val)) begin
                            ptr   <= byte_val[ADDR_W-1:0];
                            phase <= PH_BURST;
                        end else begin
                            phase <= PH_DRAIN;
                        end
                    end
                    PH_BURST: begin
                        req.en   <= 1'b1;
                        req.addr <= ptr;
                        req.data <= byte_val;
                        if (is_last_data(ptr)) phase <= PH_DRAIN;
                        else                   ptr   <= ptr + 1'b1;
                    end
                    PH_CTRL: begin
                        req.en   <= 1'b1;
                        req.addr <= ADDR_W'(CTRL_ADDR);
                        req.data <= byte_val;
                        phase    <= PH_DRAIN;
                    end
                    default: phase <= PH_DRAIN;
                endcase
            end
        end
    end

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        req.en |=> !req.en);

    // R8
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        req.en |-> (req.addr <= ADDR_W'(CTRL_ADDR)));

    // R10
    frame_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_s) |=> (phase == PH_OPCODE));

    // R5
    burst_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DRAIN) |=> !req.en);
endmodule

// File: rtl/spi_regwr.sv
module spi_regwr
    import spi_regwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    logic              cs_n_s, sck_s, mosi_s;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_val;
    wr_req_t           req;

    spi_regwr_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sck, mosi}),
        .q   ({cs_n_s, sck_s, mosi_s})
    );

    spi_regwr_deser i_deser (
        .clk      (clk),
        .rst      (rst),
        .cs_n_s   (cs_n_s),
        .sck_s    (sck_s),
        .mosi_s   (mosi_s),
        .byte_vld (byte_vld),
        .byte_val (byte_val)
    );

    spi_regwr_decode i_decode (
        .clk      (clk),
        .rst      (rst),
        .cs_n_s   (cs_n_s),
        .byte_vld (byte_vld),
        .byte_val (byte_val),
        .req      (req)
    );

    assign wr_en   = req.en;
    assign wr_addr = req.addr;
    assign wr_data = req.data;

    // R2
    strobe_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !$past(cs_n_s, 2));
endmodule

// File: tb/test_spi_regwr.sv
module test_spi_regwr;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       wr_en;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;

    localparam int HALF = 10;

    int vectors = 0;
    int fails   = 0;

    logic [7:0] exp_regs [17];
    logic [7:0] act_regs [17];
    int         exp_cnt = 0;
    int         act_cnt = 0;
    logic [7:0] frame [32];

    always #10 clk = ~clk;

    spi_regwr i_spi_regwr (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (!rst && wr_en) begin
            if (wr_addr <= 5'd16) act_regs[wr_addr] = wr_data;
            act_cnt++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic half_bit();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_frame(input int n, input int extra_bits);
        cs_n = 1'b0;
        half_bit();
        for (int i = 0; i < n * 8 + extra_bits; i++) begin
            mosi = frame[i / 8][7 - (i % 8)];
            half_bit();
            sck = 1'b1;
            half_bit();
            sck = 1'b0;
        end
        half_bit();
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    // reference: partial trailing bits never produce a write
    task automatic model(input int n);
        if (n >= 2 && frame[0] == 8'h01 && frame[1] <= 8'h0F) begin
            int a = int'(frame[1]);
            for (int i = 2; i < n; i++) begin
                if (a <= 15) begin
                    exp_regs[a] = frame[i];
                    exp_cnt++;
                    a++;
                end
            end
        end else if (n >= 2 && frame[0] == 8'h03) begin
            exp_regs[16] = frame[1];
            exp_cnt++;
        end
    endtask

    task automatic run(input string req, input int n, input int extra_bits);
        model(n);
        send_frame(n, extra_bits);
        chk({req, " strobe count"}, act_cnt, exp_cnt);
        for (int r = 0; r < 17; r++) begin
            if (act_regs[r] !== exp_regs[r]) begin
                chk($sformatf("%s reg %0h", req, r), int'(act_regs[r]), int'(exp_regs[r]));
            end
        end
        vectors++;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int seed = 32'h5EED;
        void'($urandom(seed));
        for (int r = 0; r < 17; r++) begin
            exp_regs[r] = 8'h00;
            act_regs[r] = 8'h00;
        end
        repeat (5) @(negedge clk);
        // R1
        chk("R1 wr_en in reset", int'(wr_en), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 wr_en after reset", int'(wr_en), 0);
        chk("R1 wr_addr after reset", int'(wr_addr), 0);
        chk("R1 wr_data after reset", int'(wr_data), 0);

        // R2 R3: burst from 0 with MSB-first patterns
        frame[0] = 8'h01; frame[1] = 8'h00;
        frame[2] = 8'h80; frame[3] = 8'h01; frame[4] = 8'hA5; frame[5] = 8'h3C;
        run("R2 R3 burst from 0", 6, 0);

        // R4: control write, trailing bytes ignored
        frame[0] = 8'h03; frame[1] = 8'h5A; frame[2] = 8'hFF; frame[3] = 8'h11;
        run("R4 control single", 4, 0);

        // R5: burst from 0x0D overruns the data registers
        frame[0] = 8'h01; frame[1] = 8'h0D;
        for (int i = 2; i < 9; i++) frame[i] = 8'hC0 + 8'(i);
        run("R5 burst overrun", 9, 0);

        // R6: unknown opcode
        frame[0] = 8'h02; frame[1] = 8'h00; frame[2] = 8'hEE; frame[3] = 8'hEE;
        run("R6 unknown opcode", 4, 0);

        // R9: start address out of range
        frame[0] = 8'h01; frame[1] = 8'h10; frame[2] = 8'h77; frame[3] = 8'h66;
        run("R9 start above range", 4, 0);

        // R7: partial byte dropped, then clean frame decodes
        frame[0] = 8'h01; frame[1] = 8'h04; frame[2] = 8'h99; frame[3] = 8'hFF;
        run("R7 partial byte", 3, 5);
        frame[0] = 8'h03; frame[1] = 8'h42;
        run("R7 R10 after partial", 2, 0);

        // R10: frame after a drained frame starts with opcode
        frame[0] = 8'h01; frame[1] = 8'h0F; frame[2] = 8'h12; frame[3] = 8'h34;
        run("R10 drain then new", 4, 0);
        frame[0] = 8'h01; frame[1] = 8'h07; frame[2] = 8'h21;
        run("R10 new frame", 3, 0);

        // random frames
        for (int t = 0; t < 30; t++) begin
            int n = 1 + int'($urandom_range(7));
            int k = int'($urandom_range(3));
            int xb = ($urandom_range(4) == 0) ? int'($urandom_range(1, 7)) : 0;
            frame[0] = (k == 0) ? 8'h03 : (k == 3) ? 8'($urandom) : 8'h01;
            frame[1] = 8'($urandom_range(18));
            for (int i = 2; i < 32; i++) frame[i] = 8'($urandom);
            run("R3 R4 R8 random", n, xb);
        end

        chk("R8 no strobe idle", int'(wr_en), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule